// File: doc/BRIEF.md
# Write-Drain Gated Doorbell Interrupt

This receive-side block takes one inbound packet stream that carries two kinds of packet: memory writes and doorbells. Write packets go straight on to a memory-write engine. The address and data in the packet reach the engine unchanged. The block counts how many writes it has handed over and how many the engine has confirmed as committed.

A doorbell is not signalled when it arrives. It waits in a small queue, tagged with the number of writes handed over before it. It is released only when the committed count has caught up with that tag. The release sets one bit of a 64-bit status register, and the interrupt follows from that bit. As a result, software that takes the interrupt always finds the data of every earlier write already in memory, however many writes made up the transfer.

Software clears status bits by writing ones. A 64-bit enable mask picks which set bits drive the interrupt. The block pushes back on the inbound stream in three cases: the doorbell queue is full, the count of uncommitted writes has reached its ceiling, or the memory engine is not ready.

Top module: `doorbell_drain_gate`

## Requirements
- R1: During and after reset the status register is all zero, the interrupt is low and a doorbell would be accepted (the queue is empty).
- R2: Packet kind is one bit: 0 means write and 1 means doorbell. A presented write drives `mem_req_valid` with `mem_addr` and `mem_data` equal to `in_addr` and `in_data`. A doorbell never drives a memory request.
- R3: A doorbell with index `in_bell` (6 bits, bit position in the status register) sets that status bit only after every write accepted before it has returned its `mem_ack`. The bit appears on the second rising edge counted from the edge that samples the last needed acknowledge. A doorbell with no outstanding earlier write sets its bit on the edge after it is accepted.
- R4: Doorbells are released strictly in arrival order, at most one per cycle. A later doorbell never sets its bit before an earlier one.
- R5: Asserting `clr_valid` clears, on the next edge, every status bit whose `clr_mask` bit is one. If a doorbell release sets the same bit in that cycle, the set wins.
- R6: `irq` is high exactly when some status bit is set and the matching `en_mask` bit is one. It follows `en_mask` without delay.
- R7: At most 4 doorbells wait at once. With 4 waiting, `in_ready` is low for a doorbell.
- R8: At most 15 writes may be uncommitted. At that count `in_ready` is low for a write and no memory request is driven.
- R9: For a write below the ceiling, `in_ready` follows `mem_req_ready`. A write is consumed only on a cycle where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Inbound packet present |
| in_ready | output | 1 | Inbound packet taken this cycle if valid |
| in_kind | input | 1 | 0 write, 1 doorbell |
| in_addr | input | 32 | Write destination address |
| in_data | input | 64 | Write payload |
| in_bell | input | 6 | Doorbell index |
| mem_req_valid | output | 1 | Write request to memory engine |
| mem_req_ready | input | 1 | Memory engine accepts request |
| mem_addr | output | 32 | Write address to memory |
| mem_data | output | 64 | Write data to memory |
| mem_ack | input | 1 | One write committed (pulse per write) |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 64 | Bits to clear |
| en_mask | input | 64 | Interrupt enable per status bit |
| status | output | 64 | Doorbell status register |
| irq | output | 1 | Interrupt request |

## Verification
A doorbell release and a software clear of the same status bit can land in the same cycle. The bench provokes this by holding a clear of one bit active while granting exactly one acknowledge to the write that gates that bit's doorbell. It then counts the cycles in which the bit reads one, and exactly one such cycle is expected, because the set wins and the held clear removes the bit an edge later. A second collision is an acknowledge that lands on the edge where the head doorbell pops while the next doorbell carries the same tag. The randomized phase produces many of these, and a behavioural queue model is compared with every output on every clock.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
   typedef enum logic {
      PKT_WRITE = 1'b0,
      PKT_BELL  = 1'b1
   } pkt_kind_e;
endpackage

// File: rtl/dbg_write_ledger.sv
// Counts writes handed to memory and writes confirmed committed.
module dbg_write_ledger #(
   parameter int OUT_W = 4,
   localparam int CNT_W = OUT_W + 1,
   localparam int CAP   = (1 << OUT_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             commit,
   output logic [CNT_W-1:0] issued,
   output logic [CNT_W-1:0] committed,
   output logic [CNT_W-1:0] outstanding,
   output logic             at_cap
);
   logic [CNT_W-1:0] issued_q, committed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issued_q    <= '0;
         committed_q <= '0;
      end else begin
         if (issue)  issued_q    <= issued_q + 1'b1;
         if (commit) committed_q <= committed_q + 1'b1;
      end
   end

   assign issued      = issued_q;
   assign committed   = committed_q;
   assign outstanding = issued_q - committed_q;
   assign at_cap      = (outstanding == CNT_W'(CAP));
endmodule

// File: rtl/dbg_bell_queue.sv
// Holds waiting doorbells with the write count that gates each one.
module dbg_bell_queue #(
   parameter int DEPTH = 4,
   parameter int BELL_W = 6,
   parameter int CNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [BELL_W-1:0] push_bell,
   input  logic [CNT_W-1:0]  push_tag,
   input  logic              pop,
   output logic              head_valid,
   output logic [BELL_W-1:0] head_bell,
   output logic [CNT_W-1:0]  head_tag,
   output logic              full
);
   generate
      if (DEPTH == 1) begin : g_single
         logic              vld_q;
         logic [BELL_W-1:0] bell_q;
         logic [CNT_W-1:0]  tag_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               bell_q <= '0;
               tag_q  <= '0;
            end else if (push) begin
               vld_q  <= 1'b1;
               bell_q <= push_bell;
               tag_q  <= push_tag;
            end else if (pop) begin
               vld_q  <= 1'b0;
            end
         end

         assign head_valid = vld_q;
         assign head_bell  = bell_q;
         assign head_tag   = tag_q;
         assign full       = vld_q;
      end else begin : g_ring
         localparam int PTR_W  = $clog2(DEPTH);
         localparam int FILL_W = $clog2(DEPTH + 1);

         logic [BELL_W-1:0] bell_mem [DEPTH];
         logic [CNT_W-1:0]  tag_mem  [DEPTH];
         logic [PTR_W-1:0]  wr_ptr, rd_ptr;
         logic [FILL_W-1:0] fill;

         function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               fill   <= '0;
               for (int i = 0; i < DEPTH; i++) begin
                  bell_mem[i] <= '0;
                  tag_mem[i]  <= '0;
               end
            end else begin
               if (push) begin
                  bell_mem[wr_ptr] <= push_bell;
                  tag_mem[wr_ptr]  <= push_tag;
                  wr_ptr           <= bump(wr_ptr);
               end
               if (pop) rd_ptr <= bump(rd_ptr);
               if (push && !pop)      fill <= fill + 1'b1;
               else if (pop && !push) fill <= fill - 1'b1;
            end
         end

         assign head_valid = (fill != '0);
         assign head_bell  = bell_mem[rd_ptr];
         assign head_tag   = tag_mem[rd_ptr];
         assign full       = (fill == FILL_W'(DEPTH));
      end
   endgenerate
endmodule

// File: rtl/dbg_bell_status.sv
// Per-source status bits: set by release, cleared by writing ones.
module dbg_bell_status #(
   parameter int BELLS = 64,
   localparam int BELL_W = $clog2(BELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_valid,
   input  logic [BELL_W-1:0] set_idx,
   input  logic              clr_valid,
   input  logic [BELLS-1:0]  clr_mask,
   output logic [BELLS-1:0]  status
);
   generate
      for (genvar b = 0; b < BELLS; b++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              bit_q <= 1'b0;
            else if (set_valid && set_idx == BELL_W'(b)) bit_q <= 1'b1;
            else if (clr_valid && clr_mask[b])       bit_q <= 1'b0;
         end
         assign status[b] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/doorbell_drain_gate.sv
module doorbell_drain_gate #(
   parameter int BELLS  = 64,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int OUT_W  = 4,
   parameter int DEPTH  = 4,
   localparam int BELL_W = $clog2(BELLS),
   localparam int CNT_W  = OUT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_kind,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   input  logic [BELL_W-1:0] in_bell,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ack,
   input  logic              clr_valid,
   input  logic [BELLS-1:0]  clr_mask,
   input  logic [BELLS-1:0]  en_mask,
   output logic [BELLS-1:0]  status,
   output logic              irq
);
   import dbg_pkg::*;

   initial begin
      if (BELLS < 2 || (1 << BELL_W) != BELLS)
         $fatal(1, "BELLS must be a power of two of at least 2");
      if (DEPTH < 1) $fatal(1, "DEPTH must be at least 1");
      if (OUT_W < 1) $fatal(1, "OUT_W must be at least 1");
   end

   logic              is_write;
   logic              wr_fire, bell_fire, release_bell;
   logic              at_cap, q_full, head_valid;
   logic [CNT_W-1:0]  issued, committed, outstanding, head_tag, drain_gap;
   logic [BELL_W-1:0] head_bell;

   assign is_write = (pkt_kind_e'(in_kind) == PKT_WRITE);

   // Writes pass through untouched; only the ceiling and memory readiness gate them.
   assign mem_req_valid = in_valid && is_write && !at_cap;
   assign mem_addr      = in_addr;
   assign mem_data      = in_data;
   assign wr_fire       = mem_req_valid && mem_req_ready;
   assign bell_fire     = in_valid && !is_write && !q_full;
   assign in_ready      = is_write ? (mem_req_ready && !at_cap) : !q_full;

   dbg_write_ledger #(.OUT_W(OUT_W)) u_ledger (
      .clk(clk), .rst_n(rst_n),
      .issue(wr_fire), .commit(mem_ack),
      .issued(issued), .committed(committed),
      .outstanding(outstanding), .at_cap(at_cap)
   );

   dbg_bell_queue #(.DEPTH(DEPTH), .BELL_W(BELL_W), .CNT_W(CNT_W)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(bell_fire), .push_bell(in_bell), .push_tag(issued),
      .pop(release_bell),
      .head_valid(head_valid), .head_bell(head_bell), .head_tag(head_tag),
      .full(q_full)
   );

   // Signed distance: committed may run past an old tag, never by more than the ceiling.
   assign drain_gap    = committed - head_tag;
   assign release_bell = head_valid && !drain_gap[CNT_W-1];

   dbg_bell_status #(.BELLS(BELLS)) u_status (
      .clk(clk), .rst_n(rst_n),
      .set_valid(release_bell), .set_idx(head_bell),
      .clr_valid(clr_valid), .clr_mask(clr_mask),
      .status(status)
   );

   assign irq = |(status & en_mask);
endmodule

// File: rtl/dbg_gate_checker.sv
module dbg_gate_checker #(
   parameter int BELLS = 64,
   parameter int CNT_W = 5,
   parameter int CAP   = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_kind,
   input logic             in_ready,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic             release_bell,
   input logic             q_full,
   input logic [CNT_W-1:0] outstanding,
   input logic             clr_valid,
   input logic [BELLS-1:0] clr_mask,
   input logic [BELLS-1:0] en_mask,
   input logic [BELLS-1:0] status,
   input logic             irq
);
   p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (status == '0));

   p_write_only_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (in_valid && !in_kind));

   p_set_needs_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status)) != '0) |-> $past(release_bell));

   p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && !release_bell) |=> ((status & $past(clr_mask)) == '0));

   p_irq_has_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((status & en_mask) != '0));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !(in_valid && in_kind && in_ready));

   p_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CNT_W'(CAP));

   p_ready_follows_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_kind && !mem_req_ready) |-> !in_ready);
endmodule

bind doorbell_drain_gate dbg_gate_checker #(
   .BELLS(BELLS), .CNT_W(CNT_W), .CAP((1 << OUT_W) - 1)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_valid(in_valid), .in_kind(in_kind), .in_ready(in_ready),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .release_bell(release_bell), .q_full(q_full), .outstanding(outstanding),
   .clr_valid(clr_valid), .clr_mask(clr_mask), .en_mask(en_mask),
   .status(status), .irq(irq)
);

// File: tb/doorbell_drain_gate_test.sv
module doorbell_drain_gate_test;
   localparam int DEPTH = 4;
   localparam int CAP   = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_kind = 1'b0;
   logic [31:0] in_addr = '0;
   logic [63:0] in_data = '0;
   logic [5:0]  in_bell = '0;
   logic        mem_req_ready = 1'b1, mem_ack = 1'b0, clr_valid = 1'b0;
   logic [63:0] clr_mask = '0, en_mask = '1;
   logic        in_ready, mem_req_valid, irq;
   logic [31:0] mem_addr;
   logic [63:0] mem_data, status;

   int checks = 0, fails = 0, cycles = 0;
   int ack_budget = 0;
   bit ack_rand = 1'b0;
   bit started = 1'b0;

   // Behavioural reference state
   int          m_iss = 0, m_com = 0;
   int          q_bell[$], q_tag[$];
   logic [63:0] m_status = '0;

   doorbell_drain_gate uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data), .in_bell(in_bell),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack),
      .clr_valid(clr_valid), .clr_mask(clr_mask), .en_mask(en_mask),
      .status(status), .irq(irq)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
      end
   endtask

   // Model update on each edge, from the inputs held since the previous edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_iss = 0; m_com = 0; m_status = '0;
         q_bell.delete(); q_tag.delete();
      end else begin
         bit rel, wr_acc, bell_acc;
         logic [63:0] nxt;
         cycles++;
         rel      = (q_bell.size() > 0) && (m_com >= q_tag[0]);
         wr_acc   = in_valid && !in_kind && mem_req_ready && ((m_iss - m_com) < CAP);
         bell_acc = in_valid && in_kind && (q_bell.size() < DEPTH);
         nxt = m_status;
         if (clr_valid) nxt = nxt & ~clr_mask;
         if (rel) begin
            nxt[q_bell[0]] = 1'b1;
            void'(q_bell.pop_front());
            void'(q_tag.pop_front());
         end
         if (bell_acc) begin
            q_bell.push_back(int'(in_bell));
            q_tag.push_back(m_iss);
         end
         if (wr_acc) m_iss++;
         if (mem_ack) m_com++;
         m_status = nxt;
      end
   end

   // Every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         bit exp_rdy, exp_mreq;
         exp_mreq = in_valid && !in_kind && ((m_iss - m_com) < CAP);
         exp_rdy  = in_kind ? (q_bell.size() < DEPTH)
                            : (mem_req_ready && ((m_iss - m_com) < CAP));
         chk(status == m_status, "R3 status", status, m_status);
         chk(irq == |(m_status & en_mask), "R6 irq", 64'(irq), 64'(|(m_status & en_mask)));
         chk(in_ready == exp_rdy, in_kind ? "R7 ready" : "R9 ready", 64'(in_ready), 64'(exp_rdy));
         chk(mem_req_valid == exp_mreq, "R2/R8 mem_req_valid", 64'(mem_req_valid), 64'(exp_mreq));
         if (exp_mreq) begin
            chk(mem_addr == in_addr, "R2 addr", 64'(mem_addr), 64'(in_addr));
            chk(mem_data == in_data, "R2 data", mem_data, in_data);
         end
      end
   end

   // Commit acknowledges, never more than outstanding
   always @(posedge clk) begin
      #5;
      if ((m_iss - m_com) > 0 && (ack_budget > 0 || (ack_rand && $urandom_range(0, 2) == 0))) begin
         mem_ack = 1'b1;
         if (ack_budget > 0) ack_budget--;
      end else begin
         mem_ack = 1'b0;
      end
   end

   always @(posedge clk) begin
      if (cycles > 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #5; end
   endtask

   task automatic hold_until_taken();
      bit ok;
      do begin
         @(negedge clk); ok = in_ready;
         @(posedge clk); #5;
      end while (!ok);
      in_valid = 1'b0;
   endtask

   task automatic put_wr(input logic [31:0] a, input logic [63:0] d);
      in_valid = 1'b1; in_kind = 1'b0; in_addr = a; in_data = d;
      hold_until_taken();
   endtask

   task automatic put_bell(input int b);
      in_valid = 1'b1; in_kind = 1'b1; in_bell = 6'(b);
      hold_until_taken();
   endtask

   task automatic clear_all();
      clr_valid = 1'b1; clr_mask = '1; idle(1);
      clr_valid = 1'b0; clr_mask = '0; idle(1);
   endtask

   initial begin
      int hi;
      in_kind = 1'b1;
      started = 1'b1;
      repeat (3) @(negedge clk);
      chk(status == '0, "R1 status in reset", status, '0);
      chk(irq == 1'b0, "R1 irq in reset", 64'(irq), 0);
      chk(in_ready == 1'b1, "R1 bell ready in reset", 64'(in_ready), 1);
      rst_n = 1'b1;
      @(posedge clk); #5;
      @(negedge clk);
      chk(status == '0, "R1 status after reset", status, '0);
      @(posedge clk); #5;

      // R3: doorbell held until its three writes commit
      for (int i = 0; i < 3; i++) put_wr(32'h1000 + 32'(i), 64'hA5A5_0000 + 64'(i));
      put_bell(5);
      idle(6);
      chk(status[5] == 1'b0, "R3 held while acks pending", 64'(status[5]), 0);
      ack_budget = 3;
      idle(8);
      chk(status[5] == 1'b1, "R3 released after drain", 64'(status[5]), 1);
      chk(irq == 1'b1, "R6 irq with enabled bit", 64'(irq), 1);

      // R5: write-one-to-clear
      clr_valid = 1'b1; clr_mask = 64'h20; idle(1);
      clr_valid = 1'b0; clr_mask = '0; idle(1);
      chk(status == '0, "R5 cleared", status, '0);

      // R4: release order with one acknowledge granted
      put_wr(32'h2000, 64'h1); put_bell(0);
      put_wr(32'h2004, 64'h2); put_bell(63);
      idle(3);
      ack_budget = 1; idle(6);
      chk(status[0] == 1'b1, "R4 first bell released", 64'(status[0]), 1);
      chk(status[63] == 1'b0, "R4 second bell still held", 64'(status[63]), 0);
      ack_budget = 1; idle(6);
      chk(status[63] == 1'b1, "R4 second bell released", 64'(status[63]), 1);
      clear_all();

      // R7: four waiting doorbells fill the queue
      put_wr(32'h3000, 64'h3);
      for (int b = 1; b <= 4; b++) put_bell(b);
      in_valid = 1'b1; in_kind = 1'b1; in_bell = 6'd9;
      idle(2);
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 full queue refuses bell", 64'(in_ready), 0);
      @(posedge clk); #5;
      ack_budget = 1;
      hold_until_taken();
      idle(8);
      chk(status[9:1] == 9'h10F, "R7 all five released", 64'(status[9:1]), 64'h10F);
      clear_all();

      // R8: ceiling on uncommitted writes
      for (int i = 0; i < CAP; i++) put_wr(32'h4000 + 32'(4 * i), 64'(i));
      in_valid = 1'b1; in_kind = 1'b0; in_addr = 32'h5000; in_data = 64'hFEED;
      idle(2);
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 ready low at ceiling", 64'(in_ready), 0);
      chk(mem_req_valid == 1'b0, "R8 no request at ceiling", 64'(mem_req_valid), 0);
      @(posedge clk); #5;
      ack_budget = CAP + 1;
      hold_until_taken();
      idle(CAP + 6);

      // R9: memory not ready stalls the write, request stays visible (R2)
      mem_req_ready = 1'b0;
      in_valid = 1'b1; in_kind = 1'b0; in_addr = 32'hCAFE_0000; in_data = 64'h0123_4567_89AB_CDEF;
      idle(2);
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 ready follows memory", 64'(in_ready), 0);
      chk(mem_addr == 32'hCAFE_0000, "R2 address unchanged", 64'(mem_addr), 64'hCAFE_0000);
      @(posedge clk); #5;
      mem_req_ready = 1'b1;
      ack_budget = 1;
      hold_until_taken();
      idle(6);

      // R5: set and clear of the same bit in one cycle, set wins
      put_wr(32'h6000, 64'h7); put_bell(7);
      clr_valid = 1'b1; clr_mask = 64'h80;
      ack_budget = 1;
      hi = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); if (status[7]) hi++;
         @(posedge clk); #5;
      end
      chk(hi == 1, "R5 set beats clear for one cycle", 64'(hi), 1);
      clr_valid = 1'b0; clr_mask = '0;

      // R6: enable mask gates the interrupt
      put_bell(9); idle(3);
      en_mask = ~64'h200; idle(1);
      @(negedge clk);
      chk(irq == 1'b0, "R6 masked source", 64'(irq), 0);
      @(posedge clk); #5;
      en_mask = 64'h200;
      @(negedge clk);
      chk(irq == 1'b1, "R6 enabled source", 64'(irq), 1);
      @(posedge clk); #5;
      clear_all();
      en_mask = '1;

      // Mixed random traffic compared against the model every cycle
      ack_rand = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         in_valid      = ($urandom_range(0, 3) != 0);
         in_kind       = ($urandom_range(0, 3) == 0);
         in_addr       = $urandom;
         in_data       = {$urandom, $urandom};
         in_bell       = 6'($urandom_range(0, 63));
         mem_req_ready = ($urandom_range(0, 4) != 0);
         clr_valid     = ($urandom_range(0, 5) == 0);
         clr_mask      = {$urandom, $urandom};
         if ($urandom_range(0, 30) == 0) en_mask = {$urandom, $urandom};
         idle(1);
      end
      in_valid = 1'b0; clr_valid = 1'b0;
      idle(40);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule